// File: doc/BRIEF.md
# ADC Precharge and Guard Sequencer

This block runs the digital side of a capacitive-sensing converter front end. Software sets an 8-bit control register. A conversion request then starts a sequence. First comes an optional precharge stage of programmable length. During that stage the block drives the external pin, the internal sampling capacitor and the guard ring to chosen levels. A one-cycle handoff pulse then tells the converter to acquire and convert. The block waits for the converter's done indication and then raises a computation strobe.

With double sampling enabled, one request runs two conversions back to back, and the strobe fires only after the second one. The second conversion can optionally use inverted precharge and guard polarities, which supports differential measurements. The control fields are copied when a sequence starts, so a register write during a sequence does not change it.

Control register fields: bit 7 is the precharge polarity (`prePol`), bit 6 enables inversion on the second conversion (`invSecond`), bit 5 is the guard polarity (`guardPol`), bit 1 selects capacitor-only precharge (`capOnly`), and bit 0 enables double sampling (`pairMode`). Bits 4 to 2 are not implemented.

Top module: `adc_precharge_seq`

## Requirements
- R1: After reset the control register reads 0x00, and `pinDrvEn`, `capDrvEn`, `pinLvl`, `capLvl`, `guardLvl`, `convGo` and `compStrobe` are all 0.
- R2: A write with `regAddr` equal to the register offset (default 0x230) stores the data masked with 0xE3. Bits 4 to 2 always read 0. A write to any other address changes nothing, and reads at any other address return 0.
- R3: When `preCount` = N > 0 is sampled with `convStart` in idle, the precharge stage (`capDrvEn` = 1) lasts exactly N cycles, starting in the cycle after the request.
- R4: During precharge with `prePol` = 1, the pin is driven high and the capacitor low. With `prePol` = 0, the pin is driven low and the capacitor high. In both cases this applies unless the levels are inverted per R10.
- R5: During precharge, `guardLvl` equals `guardPol`, unless it is inverted per R10.
- R6: With `capOnly` = 1, `pinDrvEn` stays 0 throughout precharge. With `capOnly` = 0, `pinDrvEn` is 1 throughout precharge.
- R7: With `preCount` = 0 there is no precharge stage, and `convGo` rises in the cycle after the request.
- R8: `convGo` is a single-cycle pulse in the cycle after the last precharge cycle.
- R9: With `pairMode` = 0, each request runs one conversion. `compStrobe` pulses for one cycle, in the cycle after `convDone` is sampled, and the block returns to idle.
- R10: With `pairMode` = 1, a second conversion starts on its own after the first `convDone`, and `compStrobe` fires only after the second. If `invSecond` = 1 as well, the second precharge uses inverted pin, capacitor and guard levels.
- R11: With `pairMode` = 0, `invSecond` has no effect.
- R12: Outside the precharge stage, `pinDrvEn`, `capDrvEn`, `pinLvl`, `capLvl` and `guardLvl` are all 0.
- R13: The control fields and `preCount` are captured when a sequence starts. A register write during the sequence does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 12 | Register access address |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| convStart | input | 1 | Request a conversion sequence (sampled in idle) |
| preCount | input | 8 | Precharge length in cycles |
| convDone | input | 1 | Converter finished the current conversion |
| pinDrvEn | output | 1 | Drive the external pin during precharge |
| pinLvl | output | 1 | Pin precharge level |
| capDrvEn | output | 1 | Drive the sampling capacitor during precharge |
| capLvl | output | 1 | Capacitor precharge level |
| guardLvl | output | 1 | Guard ring level |
| convGo | output | 1 | Handoff pulse to acquire and convert |
| compStrobe | output | 1 | Computation strobe |

## Verification
The bench sweeps all 32 settings of the five implemented control bits, each with precharge lengths of 0, 1 and 3. This separates the skip case, the single-cycle stage and a stage whose counter must actually count down. Within each sweep, the pair-mode settings show whether the second conversion is launched and whether its levels are inverted. The settings without pair mode show that inversion stays dormant and that the strobe fires once per request. Separate directed writes check the field masking and address decoding, and a register write made during a sequence shows that the running sequence keeps its captured configuration.

// File: rtl/adc_pre_pkg.sv
package adc_pre_pkg;
  localparam int REG_W = 8;
  localparam int B_PREPOL = 7;
  localparam int B_INV    = 6;
  localparam int B_GUARD  = 5;
  localparam int B_CAPONLY = 1;
  localparam int B_PAIR   = 0;
  localparam logic [REG_W-1:0] IMPL_MASK =
    (REG_W'(1) << B_PREPOL) | (REG_W'(1) << B_INV) | (REG_W'(1) << B_GUARD) |
    (REG_W'(1) << B_CAPONLY) | (REG_W'(1) << B_PAIR);

  typedef struct packed {
    logic startSeq;
    logic preActive;
    logic handoff;
    logic convEnd;
  } seqStrobes_t;

  typedef struct packed {
    logic prePol;
    logic invSecond;
    logic guardPol;
    logic capOnly;
    logic pairMode;
  } preCfg_t;
endpackage

// File: rtl/adc_pre_ctrl.sv
module adc_pre_ctrl
  import adc_pre_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic [CNT_W-1:0] preCount,
  input  logic             convDone,
  input  logic             needSecond,
  output seqStrobes_t      stb
);
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_HAND, S_WAIT} seqState_t;

  seqState_t state, nextState;
  logic [CNT_W-1:0] cnt, cntLatch;

  always_comb begin
    nextState = state;
    stb = '0;
    case (state)
      S_IDLE: if (convStart) begin
        stb.startSeq = 1'b1;
        nextState = (preCount == '0) ? S_HAND : S_PRE;
      end
      S_PRE: begin
        stb.preActive = 1'b1;
        if (cnt == '0) nextState = S_HAND;
      end
      S_HAND: begin
        stb.handoff = 1'b1;
        nextState = S_WAIT;
      end
      S_WAIT: if (convDone) begin
        stb.convEnd = 1'b1;
        if (needSecond) nextState = (cntLatch == '0) ? S_HAND : S_PRE;
        else nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt <= '0;
      cntLatch <= '0;
    end else begin
      state <= nextState;
      if (stb.startSeq) begin
        cntLatch <= preCount;
        cnt <= preCount - 1'b1;
      end else if (stb.preActive) begin
        cnt <= cnt - 1'b1;
      end else if (stb.convEnd && needSecond) begin
        cnt <= cntLatch - 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_pre_dp.sv
module adc_pre_dp
  import adc_pre_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h230
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  seqStrobes_t       stb,
  output logic              needSecond,
  output logic              pinDrvEn,
  output logic              pinLvl,
  output logic              capDrvEn,
  output logic              capLvl,
  output logic              guardLvl,
  output logic              convGo,
  output logic              compStrobe
);
  logic [REG_W-1:0] ctrlReg;
  preCfg_t cfg;
  logic secondPhase;
  logic flip, polEff;
  logic addrHit;

  assign addrHit = (regAddr == REG_ADDR);
  assign regRdData = addrHit ? ctrlReg : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (regWrEn && addrHit) ctrlReg <= regWrData & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
      secondPhase <= 1'b0;
      compStrobe <= 1'b0;
    end else begin
      compStrobe <= stb.convEnd && !needSecond;
      if (stb.startSeq) begin
        cfg.prePol    <= ctrlReg[B_PREPOL];
        cfg.invSecond <= ctrlReg[B_INV];
        cfg.guardPol  <= ctrlReg[B_GUARD];
        cfg.capOnly   <= ctrlReg[B_CAPONLY];
        cfg.pairMode  <= ctrlReg[B_PAIR];
        secondPhase   <= 1'b0;
      end else if (stb.convEnd) begin
        secondPhase <= needSecond;
      end
    end
  end

  assign needSecond = cfg.pairMode && !secondPhase;
  assign flip = cfg.pairMode && cfg.invSecond && secondPhase;
  assign polEff = cfg.prePol ^ flip;

  assign capDrvEn = stb.preActive;
  assign pinDrvEn = stb.preActive && !cfg.capOnly;
  assign pinLvl   = stb.preActive && polEff;
  assign capLvl   = stb.preActive && !polEff;
  assign guardLvl = stb.preActive && (cfg.guardPol ^ flip);
  assign convGo   = stb.handoff;
endmodule

// File: rtl/adc_precharge_seq.sv
module adc_precharge_seq
  import adc_pre_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h230,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              convStart,
  input  logic [CNT_W-1:0]  preCount,
  input  logic              convDone,
  output logic              pinDrvEn,
  output logic              pinLvl,
  output logic              capDrvEn,
  output logic              capLvl,
  output logic              guardLvl,
  output logic              convGo,
  output logic              compStrobe
);
  seqStrobes_t stb;
  logic needSecond;

  adc_pre_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .preCount(preCount),
    .convDone(convDone), .needSecond(needSecond), .stb(stb)
  );

  adc_pre_dp #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .stb(stb),
    .needSecond(needSecond), .pinDrvEn(pinDrvEn), .pinLvl(pinLvl),
    .capDrvEn(capDrvEn), .capLvl(capLvl), .guardLvl(guardLvl),
    .convGo(convGo), .compStrobe(compStrobe)
  );
endmodule

// File: rtl/adc_precharge_seq_chk.sv
module adc_precharge_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdData,
  input logic       pinDrvEn,
  input logic       pinLvl,
  input logic       capDrvEn,
  input logic       capLvl,
  input logic       guardLvl,
  input logic       convGo,
  input logic       compStrobe
);
  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[4:2] == 3'b000);
  a_r6_pin_needs_cap: assert property (@(posedge clk) disable iff (!rstN)
    pinDrvEn |-> capDrvEn);
  a_r4_levels_opposite: assert property (@(posedge clk) disable iff (!rstN)
    capDrvEn |-> (pinLvl != capLvl));
  a_r3_levels_steady: assert property (@(posedge clk) disable iff (!rstN)
    (capDrvEn && $past(capDrvEn)) |-> ($stable(capLvl) && $stable(guardLvl)));
  a_r8_go_single: assert property (@(posedge clk) disable iff (!rstN)
    convGo |=> !convGo);
  a_r12_quiet_at_go: assert property (@(posedge clk) disable iff (!rstN)
    convGo |-> !(capDrvEn || pinDrvEn || pinLvl || capLvl || guardLvl));
  a_r12_quiet_off: assert property (@(posedge clk) disable iff (!rstN)
    !capDrvEn |-> !(pinDrvEn || pinLvl || capLvl || guardLvl));
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    compStrobe |=> !compStrobe);
endmodule

bind adc_precharge_seq adc_precharge_seq_chk i_chk (
  .clk(clk), .rstN(rstN), .regRdData(regRdData), .pinDrvEn(pinDrvEn),
  .pinLvl(pinLvl), .capDrvEn(capDrvEn), .capLvl(capLvl), .guardLvl(guardLvl),
  .convGo(convGo), .compStrobe(compStrobe)
);

// File: tb/test_adc_precharge_seq.sv
`timescale 1ns/1ps
module test_adc_precharge_seq;
  localparam logic [11:0] OFS = 12'h230;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] regAddr = OFS;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic convStart = 1'b0;
  logic [7:0] preCount = '0;
  logic convDone = 1'b0;
  logic pinDrvEn, pinLvl, capDrvEn, capLvl, guardLvl, convGo, compStrobe;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_precharge_seq i_adc_precharge_seq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .convStart(convStart),
    .preCount(preCount), .convDone(convDone), .pinDrvEn(pinDrvEn),
    .pinLvl(pinLvl), .capDrvEn(capDrvEn), .capLvl(capLvl),
    .guardLvl(guardLvl), .convGo(convGo), .compStrobe(compStrobe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = OFS;
  endtask

  // One request; clobber writes the register during the first precharge cycle
  task automatic runSeq(input logic [7:0] cfg, input int n, input bit clobber);
    logic [7:0] eff;
    bit pair, inv;
    int convs;
    eff = cfg & 8'hE3;
    pair = eff[0];
    inv = eff[0] & eff[6];
    convs = pair ? 2 : 1;
    regWrite(OFS, cfg);
    check("R2 readback", regRdData, eff);
    preCount = 8'(n);
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    for (int k = 0; k < convs; k++) begin
      int pre;
      bit f;
      pre = 0;
      f = (k == 1) && inv;
      while (!convGo && pre < 300) begin
        if (clobber && k == 0 && pre == 0) begin
          regWrEn = 1'b1; regWrData = cfg ^ 8'hE3;
        end else regWrEn = 1'b0;
        check(clobber ? "R13 cap drive" : "R3 cap drive", capDrvEn, 1);
        check(clobber ? "R13 pin level" : (f ? "R10 pin level" : "R4 pin level"), pinLvl, eff[7] ^ f);
        check("R4 cap level", capLvl, !(eff[7] ^ f));
        check(f ? "R10 guard level" : "R5 guard level", guardLvl, eff[5] ^ f);
        check("R6 pin drive", pinDrvEn, !eff[1]);
        pre++;
        @(negedge clk);
      end
      regWrEn = 1'b0;
      check(n == 0 ? "R7 no precharge" : "R3 precharge length", pre, n);
      check("R12 quiet at handoff", {pinDrvEn, capDrvEn, pinLvl, capLvl, guardLvl}, 0);
      @(negedge clk);
      check("R8 go single", convGo, 0);
      check("R12 quiet while waiting", {pinDrvEn, capDrvEn, pinLvl, capLvl, guardLvl}, 0);
      check("R9 no early strobe", compStrobe, 0);
      @(negedge clk);
      convDone = 1'b1;
      @(negedge clk);
      convDone = 1'b0;
      if (k == convs - 1) check(pair ? "R10 strobe after pair" : "R9 strobe", compStrobe, 1);
      else check("R10 no strobe after first", compStrobe, 0);
    end
    @(negedge clk);
    check("R9 strobe one cycle", compStrobe, 0);
    check("R9 back to idle", {convGo, capDrvEn}, 0);
    if (clobber) check("R13 write landed", regRdData, (cfg ^ 8'hE3) & 8'hE3);
  endtask

  initial begin
    #100000000;
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 register reset", regRdData, 8'h00);
    check("R1 outputs reset", {pinDrvEn, pinLvl, capDrvEn, capLvl, guardLvl, convGo, compStrobe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    regWrite(OFS, 8'hFF);
    check("R2 mask all ones", regRdData, 8'hE3);
    regWrite(OFS, 8'h1C);
    check("R2 unimplemented ignored", regRdData, 8'h00);
    regWrite(12'h231, 8'hA1);
    check("R2 other address write ignored", regRdData, 8'h00);
    regAddr = 12'h231;
    regWrite(OFS, 8'hA1);
    regAddr = 12'h22F;
    #1 check("R2 other address reads zero", regRdData, 8'h00);
    regAddr = OFS;
    #1 check("R2 value kept", regRdData, 8'hA1);
    for (int c = 0; c < 32; c++) begin
      logic [7:0] cfg;
      cfg = {c[4], c[3], c[2], 3'b000, c[1], c[0]};
      runSeq(cfg, 0, 1'b0);
      runSeq(cfg, 1, 1'b0);
      runSeq(cfg, 3, 1'b0);
    end
    // R11: invSecond alone must leave a single conversion untouched
    runSeq(8'hC0, 2, 1'b0);
    runSeq(8'h40, 2, 1'b0);
    // R13: mid-sequence register write
    runSeq(8'hA0, 4, 1'b1);
    runSeq(8'h41, 3, 1'b1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule